// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their signed product of `2*WIDTH` bits. It uses a single add/subtract adder and a shifting product register. One multiplication step runs per clock.

The product register is built from three parts:
- an upper accumulator, which starts at zero;
- the multiplier, in the low half;
- one extra bit to the right of the multiplier, which starts at 0.

Each step looks at the lowest multiplier bit and the extra bit, and picks one of three actions on the accumulator: subtract the multiplicand, add it, or leave it alone. The whole register then shifts right by one, and the sign bit is copied into the top. Signed operands therefore need no conversion to sign and magnitude.

To use the block, hold the two operands and pulse `start` while the block is idle. `busy` stays high for exactly `WIDTH` step cycles. Then `done` pulses for one cycle with the final product on `product`. The product stays there until the next operation is accepted.

Top module: `booth_mult`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while idle makes `busy` go high on the next cycle. `busy` then stays high for exactly `WIDTH` cycles. In the cycle after that, `done` is high for exactly one cycle and `busy` is low.
- R3: When `done` is high, `product` equals the signed product of the two operands captured at start. This holds for every operand pair, including the most negative value in either or both positions.
- R4: The operands are captured in the cycle `start` is accepted. Changing `mcand` or `mplier` while `busy` is high has no effect on the result.
- R5: A `start` pulse while `busy` is high is ignored. The running operation keeps its length and its result.
- R6: After `done`, `product` holds its value and `done` stays low until the next `start` is accepted, whatever the operand inputs do.
- R7: A `start` that is high in the same cycle as `done` is accepted. `busy` rises on the next cycle and the new result follows `WIDTH` cycles later.
- R8: Recoding follows the pair (lowest multiplier bit, extra bit): 10 subtracts the multiplicand, 01 adds it, 00 and 11 only shift. With `WIDTH` = 4, 2 × 7 yields hexadecimal 0E and 2 × (−3) yields hexadecimal FA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while the step cycles run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next start |

## Verification
Two events can fall in the same cycle: the completion pulse of one multiplication and the acceptance of the next `start`. The bench provokes this by driving `start` with fresh operands in the very cycle `done` is observed high. It then judges the result in two steps. First, `busy` must rise on the following cycle. Second, the second product must match its own signed reference, with no trace of the first. The bench also raises `start` again while a run is in progress, and checks that the run's length and result are unchanged.

// File: rtl/booth_pkg.sv
`timescale 1ns/1ps
package booth_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic step;
  } dpCtrl_t;

endpackage

// File: rtl/booth_recode.sv
`timescale 1ns/1ps
module booth_recode
  import booth_pkg::*;
(
  input  logic     curBit,
  input  logic     rightBit,
  output boothOp_t op
);

  always_comb begin
    unique case ({curBit, rightBit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/booth_datapath.sv
`timescale 1ns/1ps
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int ACC_W = WIDTH + 1;
  localparam int REG_W = ACC_W + WIDTH + 1;

  logic [ACC_W-1:0] accReg;
  logic [WIDTH-1:0] lowReg;
  logic [WIDTH-1:0] mcandReg;
  logic             extraBit;

  boothOp_t         op;
  logic [ACC_W-1:0] mcandExt;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] carryIn;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] accNext;
  logic [REG_W-1:0] joined;
  logic [REG_W-1:0] shifted;

  booth_recode u_recode (
    .curBit  (lowReg[0]),
    .rightBit(extraBit),
    .op      (op)
  );

  // One adder: subtraction feeds the inverted multiplicand plus a carry of one
  always_comb begin
    mcandExt = {mcandReg[WIDTH-1], mcandReg};
    addend   = (op == OP_SUB) ? ~mcandExt : mcandExt;
    carryIn  = {{(ACC_W-1){1'b0}}, (op == OP_SUB)};
    sum      = accReg + addend + carryIn;
    accNext  = (op == OP_NONE) ? accReg : sum;
    joined   = {accNext, lowReg, extraBit};
    shifted  = {joined[REG_W-1], joined[REG_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      lowReg   <= '0;
      mcandReg <= '0;
      extraBit <= 1'b0;
    end else if (ctrl.load) begin
      accReg   <= '0;
      lowReg   <= mplier;
      mcandReg <= mcand;
      extraBit <= 1'b0;
    end else if (ctrl.step) begin
      accReg   <= shifted[REG_W-1 -: ACC_W];
      lowReg   <= shifted[WIDTH:1];
      extraBit <= shifted[0];
    end
  end

  assign product = {accReg[WIDTH-1:0], lowReg};

endmodule

// File: rtl/booth_control.sv
`timescale 1ns/1ps
module booth_control
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end else if (ctrl.step) begin
        if (stepCnt == LAST_STEP) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/booth_mult.sv
`timescale 1ns/1ps
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  dpCtrl_t ctrl;

  booth_control #(.WIDTH(WIDTH)) u_control (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .mcand  (mcand),
    .mplier (mplier),
    .product(product)
  );

endmodule

// File: rtl/booth_mult_checker.sv
`timescale 1ns/1ps
module booth_mult_checker #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0]          capA;
  logic [WIDTH-1:0]          capB;
  logic [31:0]               runLen;
  logic signed [2*WIDTH-1:0] refProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA   <= '0;
      capB   <= '0;
      runLen <= '0;
    end else if (start && !busy) begin
      capA   <= mcand;
      capB   <= mplier;
      runLen <= '0;
    end else if (busy) begin
      runLen <= runLen + 1;
    end
  end

  always_comb begin
    refProd = $signed({{WIDTH{capA[WIDTH-1]}}, capA}) *
              $signed({{WIDTH{capB[WIDTH-1]}}, capB});
  end

  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: completion never overlaps the running phase
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2 / R5: the run lasts exactly WIDTH cycles, even with start pulses inside
  assert_run_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == WIDTH));

  // R3: the result matches the signed product of the captured operands
  assert_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($signed(product) == refProd));

  // R6: the product holds while idle without a start
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

  // R7: a start in the completion cycle is accepted
  assert_chain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> busy);

endmodule

bind booth_mult booth_mult_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .mcand  (mcand),
  .mplier (mplier),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/booth_mult_bench.sv
`timescale 1ns/1ps
module booth_mult_bench;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  booth_mult #(.WIDTH(W)) u_booth_mult (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mcand  (mcand),
    .mplier (mplier),
    .busy   (busy),
    .done   (done),
    .product(product)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    int ia;
    int ib;
    int p;
    ia = $signed(a);
    ib = $signed(b);
    p  = ia * ib;
    return p[2*W-1:0];
  endfunction

  // Called at a negedge; leaves the bench at the negedge where done is high.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit disturb, input string tag);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy after start"}, 64'(busy), 64'd1);
    for (int k = 0; k < W - 1; k++) begin
      if (disturb) begin
        start  = 1'b1;
        mcand  = ~a;
        mplier = b ^ W'(k + 5);
      end
      @(negedge clk);
      check({tag, " R2 busy during run"}, 64'({busy, done}), 64'b10);
    end
    start = 1'b0;
    @(negedge clk);
    check({tag, " R2 done with busy low"}, 64'({busy, done}), 64'b01);
    check({tag, " R3 product"}, 64'(product), 64'(refMul(a, b)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] held;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 reset asserted", 64'({busy, done, product}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({busy, done, product}), 64'd0);

    // R8: recoding examples
    runOp(4'd2, 4'd7, 1'b0, "R8 2x7");
    check("R8 2x7 value", 64'(product), 64'h0E);
    @(negedge clk);
    runOp(4'd2, 4'hD, 1'b0, "R8 2x-3");
    check("R8 2x-3 value", 64'(product), 64'hFA);

    // R6: hold after completion while inputs wander
    held = product;
    for (int k = 0; k < 4; k++) begin
      mcand  = W'(k * 3 + 1);
      mplier = W'(k * 5 + 2);
      @(negedge clk);
      check("R6 done low while idle", 64'(done), 64'd0);
      check("R6 product held", 64'(product), 64'(held));
    end

    // R3: exhaustive sweep including the most negative value
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        runOp(W'(i), W'(j), 1'b0, "R3 sweep");
        @(negedge clk);
      end
    end

    // R4 / R5: operand changes and start pulses while busy
    runOp(4'h8, 4'h8, 1'b1, "R4 R5 disturb min*min");
    @(negedge clk);
    runOp(4'h9, 4'h7, 1'b1, "R4 R5 disturb -7*7");

    // R7: start in the same cycle as done, chained several times
    runOp(4'h8, 4'h3, 1'b0, "R7 chain a");
    runOp(4'h5, 4'h8, 1'b0, "R7 chain b");
    runOp(4'hF, 4'hF, 1'b0, "R7 chain c");
    @(negedge clk);
    check("R2 done is one cycle", 64'(done), 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule